// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator

This block produces two independent pulse-width modulated outputs. It is programmed through a simple 32-bit register bus. Each channel counts input clock cycles over a programmed period and holds its output at the active level while the count is below a programmed duty value. Each channel has its own period and duty registers. The two channels share a single control word, with one byte per channel. Each byte carries an enable bit, a polarity inversion bit and a mode bit.

Software writes the period and duty registers and then sets the mode and enable bits. The channel starts at count zero on the next cycle. A change to the period or duty while a channel runs is held back until the current period ends, so a change never cuts a pulse short. Every register reads back the last value written.

Top module: `pwm2_top`

## Requirements
- R1: After a synchronous reset, every register reads as 0 and both outputs are low.
- R2: The control word (offset 0x000), the period registers (0x010 for channel 0, 0x020 for channel 1) and the duty registers (0x014 for channel 0, 0x024 for channel 1) each read back the last full 32-bit value written, including unused control bits. Read data appears on the cycle after the read enable.
- R3: A read from any other offset returns 0.
- R4: In control byte n (bits 8n+7..8n), bit 0 is enable and bit 7 is mode. A channel with both bits set counts 0 to period-1 and wraps. Its output is high while the count is below duty, and the first cycle after the enabling write is count 0. The two channels run independently.
- R5: A period value of 0 or 1 behaves as a period of 2.
- R6: A duty value greater than or equal to the period keeps the output high for the whole period.
- R7: Bit 4 of the control byte inverts the channel output, in both the running and the inactive state.
- R8: A channel with enable clear or mode clear holds its count at 0. Its output sits at the inactive level: low, or high when polarity is set. When the channel is enabled again, it restarts from count 0.
- R9: A period or duty written while a channel runs takes effect only after the current period wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| pwm_o | output | 2 | Channel outputs, bit n for channel n |

## Verification
A counter or shadow register with the wrong value shows up on the channel output within one period. It appears as a pulse edge in the wrong cycle, because the bench predicts the level of every cycle from the programmed period, duty and polarity. A shadow register loaded at the wrong time shows up within the same period as the write: the rest of that period takes the new shape instead of the old one. Corrupted register storage shows up on the read that follows it, one cycle after the strobe.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    parameter int unsigned NCH = 2;   // channel count (at most 4 byte lanes)
    parameter int unsigned DW  = 32;  // register and counter width
    parameter int unsigned AW  = 12;  // bus byte-address width

    localparam int unsigned CHW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int unsigned CTRL_OFF  = 'h000;
    localparam int unsigned PER_BASE  = 'h010;
    localparam int unsigned DUTY_BASE = 'h014;
    localparam int unsigned STRIDE    = 'h010;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned POL_BIT   = 4;
    localparam int unsigned MODE_BIT  = 7;
    localparam int unsigned MIN_PER   = 2;

    typedef struct packed {
        logic mode;
        logic pol;
        logic en;
    } ch_cfg_t;

    typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_PER, SEL_DUTY} reg_kind_t;

    typedef struct packed {
        reg_kind_t        kind;
        logic [CHW-1:0]   ch;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = SEL_NONE;
        s.ch   = '0;
        if (a == AW'(CTRL_OFF)) s.kind = SEL_CTRL;
        for (int c = 0; c < NCH; c++) begin
            if (a == AW'(PER_BASE + c * STRIDE)) begin
                s.kind = SEL_PER;
                s.ch   = CHW'(c);
            end
            if (a == AW'(DUTY_BASE + c * STRIDE)) begin
                s.kind = SEL_DUTY;
                s.ch   = CHW'(c);
            end
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] clamp_period(input logic [DW-1:0] p);
        return (p < DW'(MIN_PER)) ? DW'(MIN_PER) : p;
    endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic                    wr_en,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rd_en,
    output logic [DW-1:0]           rd_data,
    output ch_cfg_t [NCH-1:0]       cfg_o,
    output logic [NCH-1:0][DW-1:0]  per_o,
    output logic [NCH-1:0][DW-1:0]  duty_o
);
    logic [DW-1:0]          ctrl_q;
    logic [NCH-1:0][DW-1:0] per_q;
    logic [NCH-1:0][DW-1:0] duty_q;
    reg_sel_t               sel;
    logic [DW-1:0]          rd_val;

    assign sel = decode_addr(addr);

    always_comb begin
        unique case (sel.kind)
            SEL_CTRL: rd_val = ctrl_q;
            SEL_PER:  rd_val = per_q[sel.ch];
            SEL_DUTY: rd_val = duty_q[sel.ch];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            per_q   <= '0;
            duty_q  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                unique case (sel.kind)
                    SEL_CTRL: ctrl_q         <= wr_data;
                    SEL_PER:  per_q[sel.ch]  <= wr_data;
                    SEL_DUTY: duty_q[sel.ch] <= wr_data;
                    default:  ;
                endcase
            end
            if (rd_en) rd_data <= rd_val;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign cfg_o[c].en   = ctrl_q[c * LANE_W + EN_BIT];
        assign cfg_o[c].pol  = ctrl_q[c * LANE_W + POL_BIT];
        assign cfg_o[c].mode = ctrl_q[c * LANE_W + MODE_BIT];
    end

    assign per_o  = per_q;
    assign duty_o = duty_q;

    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && (decode_addr($past(addr)).kind == SEL_NONE) |-> rd_data == '0); // R3
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
    import pwm2_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ch_cfg_t       cfg,
    input  logic [DW-1:0] period,
    input  logic [DW-1:0] duty,
    output logic          pwm_o
);
    logic          active;
    logic [DW-1:0] cnt;
    logic [DW-1:0] per_act;
    logic [DW-1:0] duty_act;
    logic          at_end;

    assign active = cfg.en & cfg.mode;
    assign at_end = (cnt >= per_act - DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            per_act  <= DW'(MIN_PER);
            duty_act <= '0;
        end else if (!active || at_end) begin
            cnt      <= '0;
            per_act  <= clamp_period(period);
            duty_act <= duty;
        end else begin
            cnt      <= cnt + DW'(1);
        end
    end

    assign pwm_o = (active && (cnt < duty_act)) ^ cfg.pol;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt < per_act); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        active && $past(active) && ($past(cnt) == $past(per_act) - DW'(1)) |-> cnt == '0); // R4
    AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        per_act >= DW'(MIN_PER)); // R5
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        active && !$past(active) |-> cnt == '0); // R8
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        active && $past(active) && cnt != '0 |-> $stable(per_act) && $stable(duty_act)); // R9
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
    import pwm2_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr_en,
    input  logic [DW-1:0]  bus_wr_data,
    input  logic           bus_rd_en,
    output logic [DW-1:0]  bus_rd_data,
    output logic [NCH-1:0] pwm_o
);
    ch_cfg_t [NCH-1:0]      cfg;
    logic [NCH-1:0][DW-1:0] per;
    logic [NCH-1:0][DW-1:0] duty;

    pwm2_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .rd_en   (bus_rd_en),
        .rd_data (bus_rd_data),
        .cfg_o   (cfg),
        .per_o   (per),
        .duty_o  (duty)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm2_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg[c]),
            .period (per[c]),
            .duty   (duty[c]),
            .pwm_o  (pwm_o[c])
        );
    end
endmodule

// File: tb/sim_pwm2_top.sv
`timescale 1ns/1ps
module sim_pwm2_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] addr = '0;
    logic        wr_en = 0;
    logic [31:0] wdata = '0;
    logic        rd_en = 0;
    logic [31:0] rdata;
    logic [1:0]  pwm;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pwm2_top u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(wr_en),
        .bus_wr_data(wdata), .bus_rd_en(rd_en), .bus_rd_data(rdata), .pwm_o(pwm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    // Predict each cycle: phase advances from ph0, high while phase < d, xor pol.
    task automatic check_seg(input int ch, input int n, input int ph0, input int p,
                             input int d, input bit pol, input string req);
        for (int i = 0; i < n; i++) begin
            int ph = (ph0 + i) % p;
            check(req, 32'(pwm[ch]), 32'((ph < d) ^ pol));
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 outputs", 32'(pwm), 32'h0);
        read_check("R1 ctrl", 12'h000, 32'h0);
        read_check("R1 per0", 12'h010, 32'h0);
        read_check("R1 duty1", 12'h024, 32'h0);
    endtask

    task automatic t_readback;
        bus_write(12'h000, 32'hA5C3_6E6E);
        bus_write(12'h010, 32'hDEAD_BEEF);
        bus_write(12'h014, 32'h0000_1234);
        bus_write(12'h020, 32'h8000_0001);
        bus_write(12'h024, 32'hFFFF_FFFF);
        read_check("R2 ctrl", 12'h000, 32'hA5C3_6E6E);
        read_check("R2 per0", 12'h010, 32'hDEAD_BEEF);
        read_check("R2 duty0", 12'h014, 32'h0000_1234);
        read_check("R2 per1", 12'h020, 32'h8000_0001);
        read_check("R2 duty1", 12'h024, 32'hFFFF_FFFF);
        check("R8 inactive low", 32'(pwm), 32'h0);
        read_check("R3 0x004", 12'h004, 32'h0);
        read_check("R3 0x018", 12'h018, 32'h0);
        read_check("R3 0x030", 12'h030, 32'h0);
        read_check("R3 0x00C", 12'h00C, 32'h0);
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_basic;
        bus_write(12'h010, 10);
        bus_write(12'h014, 3);
        bus_write(12'h020, 6);
        bus_write(12'h024, 2);
        bus_write(12'h000, 32'h0000_0081);
        check("R4 ch1 idle", 32'(pwm[1]), 32'h0);
        check_seg(0, 25, 0, 10, 3, 0, "R4 ch0");
        bus_write(12'h000, 32'h0000_8100);
        check("R4 ch0 idle", 32'(pwm[0]), 32'h0);
        check_seg(1, 14, 0, 6, 2, 0, "R4 ch1");
        bus_write(12'h000, 32'h0);
        bus_write(12'h010, 4);
        bus_write(12'h014, 1);
        bus_write(12'h020, 3);
        bus_write(12'h024, 2);
        bus_write(12'h000, 32'h0000_8181);
        for (int i = 0; i < 12; i++) begin
            check("R4 both ch0", 32'(pwm[0]), 32'(((i % 4) < 1)));
            check("R4 both ch1", 32'(pwm[1]), 32'(((i % 3) < 2)));
            @(negedge clk);
        end
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_min_period;
        bus_write(12'h010, 1);
        bus_write(12'h014, 1);
        bus_write(12'h000, 32'h81);
        check_seg(0, 8, 0, 2, 1, 0, "R5 period1");
        bus_write(12'h000, 32'h0);
        bus_write(12'h010, 0);
        bus_write(12'h000, 32'h81);
        check_seg(0, 8, 0, 2, 1, 0, "R5 period0");
        read_check("R5 per0 raw", 12'h010, 32'h0);
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_full_duty;
        bus_write(12'h010, 5);
        bus_write(12'h014, 5);
        bus_write(12'h000, 32'h81);
        check_seg(0, 12, 0, 5, 5, 0, "R6 duty=period");
        bus_write(12'h000, 32'h0);
        bus_write(12'h014, 100);
        bus_write(12'h000, 32'h81);
        check_seg(0, 12, 0, 5, 100, 0, "R6 duty>period");
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_polarity;
        bus_write(12'h010, 6);
        bus_write(12'h014, 2);
        bus_write(12'h000, 32'h10);
        check_seg(0, 3, 0, 6, 0, 1, "R7 inactive high");
        bus_write(12'h000, 32'h91);
        check_seg(0, 12, 0, 6, 2, 1, "R7 inverted");
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_disable;
        bus_write(12'h010, 10);
        bus_write(12'h014, 4);
        bus_write(12'h000, 32'h81);
        check_seg(0, 5, 0, 10, 4, 0, "R8 run");
        bus_write(12'h000, 32'h80);
        check_seg(0, 6, 0, 10, 0, 0, "R8 enable clear");
        bus_write(12'h000, 32'h01);
        check_seg(0, 4, 0, 10, 0, 0, "R8 mode clear");
        bus_write(12'h000, 32'h81);
        check_seg(0, 12, 0, 10, 4, 0, "R8 restart");
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_update;
        bus_write(12'h010, 10);
        bus_write(12'h014, 3);
        bus_write(12'h000, 32'h81);
        check_seg(0, 5, 0, 10, 3, 0, "R9 before");
        bus_write(12'h014, 7);
        check_seg(0, 4, 6, 10, 3, 0, "R9 old duty held");
        check_seg(0, 20, 0, 10, 7, 0, "R9 new duty");
        bus_write(12'h010, 4);
        check_seg(0, 9, 1, 10, 7, 0, "R9 old period held");
        check_seg(0, 8, 0, 4, 7, 0, "R9 new period");
        bus_write(12'h000, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_readback();
        t_basic();
        t_min_period();
        t_full_duty();
        t_polarity();
        t_disable();
        t_update();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule